// File: doc/BRIEF.md
# Linear Sensor Timing Driver

This block runs on a fast system clock and produces every timing signal a 128-pixel linear photodiode array needs. It divides the system clock down to a sensor clock. It issues the start pulse that opens each readout, and it gives the downstream converter one sample strobe per pixel, placed a programmable number of system cycles after the sensor clock edge that presents that pixel. The converter itself and the analog path are outside the block.

A frame is the start pulse plus 129 sensor clock rises, then a programmable number of further idle rises. Because the array resets its integrators during the first 18 clocks after the start pulse, the exposure time equals the spacing of the start pulses minus that reset window, and the idle count sets it. The controller either runs one frame per request or chains frames back to back. The divider, settle delay and idle count are captured once per frame, at the moment the start pulse is raised.

Top module: `lsa_timing_ctrl`

## Requirements
- R1: After reset, sensor_clk, sensor_si, adc_sample and frame_done are low and pixel_index is 0.
- R2: While a frame runs, each high phase and each low phase of sensor_clk lasts H system cycles, where H = max(half_div, MIN_HALF_DIV). When no frame runs, sensor_clk stays low.
- R3: A start request accepted while idle raises sensor_si exactly H system cycles before the first sensor_clk rise. sensor_si drops in the same cycle as the sensor_clk fall that follows that first rise, so it is low before the second rise.
- R4: One frame contains P = NPIX + 1 + max(idle_clks, 1) sensor_clk rises, so start pulses are never less than NPIX + 2 rises apart. After the fall that follows rise P, a single-shot run stops with sensor_clk low.
- R5: adc_sample is a one-cycle pulse that comes D system cycles after each of rises 1 to NPIX, and after no other rise. D = 1 when settle_dly is 0, D = 2H-1 when settle_dly exceeds 2H-1, and D = settle_dly otherwise.
- R6: While adc_sample is high, pixel_index equals the rise number minus one, which runs from 0 to NPIX-1.
- R7: frame_done is high for exactly one system cycle per frame: the first cycle in which sensor_clk is high for rise NPIX+1.
- R8: When continuous is high at the end of a frame, sensor_si rises together with that frame's final sensor_clk fall, and the next frame starts with no gap. When continuous is low at that point, the run stops.
- R9: Changes to half_div, settle_dly and idle_clks during a frame do not affect that frame. A start request while a frame runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request for a frame when idle |
| continuous | input | 1 | Chain frames back to back |
| half_div | input | DIV_W | Sensor clock half period in system cycles |
| idle_clks | input | INT_W | Extra sensor clocks after the readout (sets exposure) |
| settle_dly | input | SET_W | System cycles from a sensor clock rise to the strobe |
| sensor_clk | output | 1 | Clock to the array |
| sensor_si | output | 1 | Start pulse to the array |
| adc_sample | output | 1 | One-cycle converter strobe |
| pixel_index | output | $clog2(NPIX) | Index of the pixel being strobed |
| frame_done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The hardest case to reach is a frame boundary. There, the final fall of one frame, the re-raising of sensor_si, the capture of new settings and the continuous flag all act on the same edge. The stimulus reaches it by running back-to-back frames, dropping continuous only after the second frame_done, and checking that the rise count between start pulses is exactly P and that the clock period has no gap. The clamped corners (half_div below the minimum, settle_dly of 0 and above 2H-1, idle_clks of 0) are reached by sweeping those settings over several frames. Mid-frame changes to the settings and a start request during a frame are applied inside a frame.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  // Frame sequencer states
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_t;

endpackage

// File: rtl/lsa_clkgen.sv
// Sensor clock divider: toggles every `half` system cycles while run is high.
module lsa_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             rise_ev,
  output logic             fall_ev
);

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic             tick;

  assign tick    = run && (div_q >= (half - 1'b1));
  assign rise_ev = tick && !sclk_q;
  assign fall_ev = tick && sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/lsa_sequencer.sv
// Frame sequencer: start pulse, rise counting, frame end, per-frame settings.
module lsa_sequencer
  import lsa_pkg::*;
#(
  parameter int NPIX         = 128,
  parameter int DIV_W        = 8,
  parameter int INT_W        = 20,
  parameter int SET_W        = 8,
  parameter int MIN_HALF_DIV = 10,
  parameter int CNT_W        = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             continuous,
  input  logic [DIV_W-1:0] half_div,
  input  logic [INT_W-1:0] idle_clks,
  input  logic [SET_W-1:0] settle_dly,
  input  logic             rise_ev,
  input  logic             fall_ev,
  output logic             run,
  output logic             si,
  output logic             frame_done,
  output logic [DIV_W-1:0] half_q,
  output logic [SET_W-1:0] settle_q,
  output logic [CNT_W-1:0] rise_num
);

  localparam logic [DIV_W-1:0] MIN_H   = DIV_W'(MIN_HALF_DIV);
  localparam logic [CNT_W-1:0] DONE_AT = CNT_W'(NPIX + 1);
  localparam int               XW      = (SET_W > DIV_W + 1) ? SET_W : DIV_W + 1;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic             si_q;
  logic             fd_q;

  // clamped settings, captured when the start pulse is raised
  logic [DIV_W-1:0] half_eff;
  logic [SET_W-1:0] settle_eff;
  logic [CNT_W-1:0] last_eff;
  logic [DIV_W:0]   lim;
  logic [XW-1:0]    s_x;
  logic [XW-1:0]    l_x;
  logic [INT_W-1:0] idle_eff;

  always_comb begin
    half_eff = (half_div < MIN_H) ? MIN_H : half_div;
    lim      = {half_eff, 1'b0} - 1'b1;
    s_x      = XW'(settle_dly);
    l_x      = XW'(lim);
    if (s_x == '0)       settle_eff = SET_W'(1);
    else if (s_x > l_x)  settle_eff = SET_W'(l_x);
    else                 settle_eff = settle_dly;
    idle_eff = (idle_clks == '0) ? INT_W'(1) : idle_clks;
    last_eff = DONE_AT + CNT_W'(idle_eff);
  end

  assign rise_num   = cnt_q + 1'b1;
  assign run        = (state_q == SEQ_SCAN);
  assign si         = si_q;
  assign frame_done = fd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      last_q   <= DONE_AT + 1'b1;
      si_q     <= 1'b0;
      fd_q     <= 1'b0;
      half_q   <= MIN_H;
      settle_q <= SET_W'(1);
    end else begin
      fd_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q  <= SEQ_SCAN;
            si_q     <= 1'b1;
            cnt_q    <= '0;
            half_q   <= half_eff;
            settle_q <= settle_eff;
            last_q   <= last_eff;
          end
        end
        default: begin
          if (rise_ev) begin
            cnt_q <= rise_num;
            if (rise_num == DONE_AT) fd_q <= 1'b1;
          end
          if (fall_ev) begin
            if (cnt_q == CNT_W'(1)) si_q <= 1'b0;
            if (cnt_q == last_q) begin
              if (continuous) begin
                si_q     <= 1'b1;
                cnt_q    <= '0;
                half_q   <= half_eff;
                settle_q <= settle_eff;
                last_q   <= last_eff;
              end else begin
                state_q  <= SEQ_IDLE;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lsa_strobe.sv
// Places one converter strobe a settle delay after each pixel-presenting rise.
module lsa_strobe #(
  parameter int NPIX  = 128,
  parameter int SET_W = 8,
  parameter int CNT_W = 21,
  parameter int PIX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_ev,
  input  logic [CNT_W-1:0] rise_num,
  input  logic [SET_W-1:0] settle,
  output logic             adc_sample,
  output logic [PIX_W-1:0] pixel_index
);

  localparam logic [CNT_W-1:0] LAST_PIX = CNT_W'(NPIX);

  logic [SET_W-1:0] dcnt_q;
  logic             armed_q;
  logic             adc_q;
  logic [PIX_W-1:0] pix_q;
  logic             pix_rise;

  assign pix_rise    = rise_ev && (rise_num <= LAST_PIX);
  assign adc_sample  = adc_q;
  assign pixel_index = pix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt_q  <= '0;
      armed_q <= 1'b0;
      adc_q   <= 1'b0;
      pix_q   <= '0;
    end else begin
      adc_q <= 1'b0;
      if (armed_q) begin
        dcnt_q <= dcnt_q - 1'b1;
        if (dcnt_q == SET_W'(1)) begin
          adc_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end
      if (pix_rise) begin
        pix_q   <= PIX_W'(rise_num - 1'b1);
        dcnt_q  <= settle;
        armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsa_timing_ctrl.sv
module lsa_timing_ctrl #(
  parameter int NPIX         = 128,
  parameter int DIV_W        = 8,
  parameter int INT_W        = 20,
  parameter int SET_W        = 8,
  parameter int MIN_HALF_DIV = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    continuous,
  input  logic [DIV_W-1:0]        half_div,
  input  logic [INT_W-1:0]        idle_clks,
  input  logic [SET_W-1:0]        settle_dly,
  output logic                    sensor_clk,
  output logic                    sensor_si,
  output logic                    adc_sample,
  output logic [$clog2(NPIX)-1:0] pixel_index,
  output logic                    frame_done
);

  localparam int PIX_W = $clog2(NPIX);
  localparam int CNT_W = $clog2(NPIX + 2 + (1 << INT_W));

  logic             run;
  logic             rise_ev;
  logic             fall_ev;
  logic [DIV_W-1:0] half_q;
  logic [SET_W-1:0] settle_q;
  logic [CNT_W-1:0] rise_num;

  lsa_sequencer #(
    .NPIX(NPIX), .DIV_W(DIV_W), .INT_W(INT_W), .SET_W(SET_W),
    .MIN_HALF_DIV(MIN_HALF_DIV), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .continuous(continuous),
    .half_div(half_div), .idle_clks(idle_clks), .settle_dly(settle_dly),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .run(run), .si(sensor_si),
    .frame_done(frame_done), .half_q(half_q), .settle_q(settle_q),
    .rise_num(rise_num)
  );

  lsa_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .half(half_q),
    .sclk(sensor_clk), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  lsa_strobe #(.NPIX(NPIX), .SET_W(SET_W), .CNT_W(CNT_W), .PIX_W(PIX_W)) u_stb (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .rise_num(rise_num),
    .settle(settle_q), .adc_sample(adc_sample), .pixel_index(pixel_index)
  );

endmodule

// File: rtl/lsa_timing_chk.sv
module lsa_timing_chk #(
  parameter int NPIX         = 128,
  parameter int MIN_HALF_DIV = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sensor_clk,
  input logic                    sensor_si,
  input logic                    adc_sample,
  input logic [$clog2(NPIX)-1:0] pixel_index,
  input logic                    frame_done
);

  logic        prev_sclk;
  logic [15:0] phase_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b0;
      phase_len <= '0;
    end else begin
      prev_sclk <= sensor_clk;
      if (sensor_clk != prev_sclk)  phase_len <= 16'd1;
      else if (phase_len != 16'hFFFF) phase_len <= phase_len + 1'b1;
    end
  end

  // R2
  min_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (sensor_clk != prev_sclk) |-> (int'(phase_len) >= MIN_HALF_DIV));

  // R3
  si_rise_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sensor_si) |-> !sensor_clk);

  // R3
  si_fall_with_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sensor_si) |-> $fell(sensor_clk));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    adc_sample |=> !adc_sample);

  // R6
  strobe_pix_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_sample && $past(adc_sample == 1'b0)) |-> $stable(pixel_index));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R7
  done_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $rose(sensor_clk));

endmodule

bind lsa_timing_ctrl lsa_timing_chk #(.NPIX(NPIX), .MIN_HALF_DIV(MIN_HALF_DIV)) u_chk (
  .clk(clk), .rst(rst), .sensor_clk(sensor_clk), .sensor_si(sensor_si),
  .adc_sample(adc_sample), .pixel_index(pixel_index), .frame_done(frame_done)
);

// File: tb/tb_lsa_timing_ctrl.sv
`timescale 1ns/1ps
module tb_lsa_timing_ctrl;

  localparam int NPIX = 128;
  localparam int MINH = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       continuous = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic [7:0] idle_clks = 8'd1;
  logic [7:0] settle_dly = 8'd1;
  logic       sensor_clk, sensor_si, adc_sample, frame_done;
  logic [6:0] pixel_index;

  always #2.5 clk = ~clk;

  lsa_timing_ctrl #(.NPIX(NPIX), .DIV_W(8), .INT_W(8), .SET_W(8), .MIN_HALF_DIV(MINH)) dut (
    .clk(clk), .rst(rst), .start(start), .continuous(continuous),
    .half_div(half_div), .idle_clks(idle_clks), .settle_dly(settle_dly),
    .sensor_clk(sensor_clk), .sensor_si(sensor_si), .adc_sample(adc_sample),
    .pixel_index(pixel_index), .frame_done(frame_done)
  );

  int checks = 0, errors = 0;
  int expN = 2, expD = 1, expP = 130;

  // monitor state
  int cyc = 0, last_rise = 0, si_rise_cyc = 0;
  int rises = 0, tot_rises = 0, between = 0, setup = 0;
  int strobes = 0, si_rises = 0, fd_cnt = 0;
  int spacing_err = 0, strobe_err = 0, pix_err = 0, si_bad = 0, fd_bad = 0;
  logic prev_sclk = 1'b0, prev_si = 1'b0;

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sensor_si && !prev_si) begin
      between = rises; rises = 0; si_rises++; si_rise_cyc = cyc;
      if (sensor_clk) si_bad++;
    end
    if (sensor_clk && !prev_sclk) begin
      if (tot_rises > 0 && (cyc - last_rise) != 2 * expN) spacing_err++;
      rises++; tot_rises++;
      if (rises == 1) setup = cyc - si_rise_cyc;
      last_rise = cyc;
    end
    if (!sensor_clk && prev_sclk && (cyc - last_rise) != expN) spacing_err++;
    if (!sensor_si && prev_si && !(prev_sclk && !sensor_clk && rises == 1)) si_bad++;
    if (adc_sample) begin
      strobes++;
      if ((cyc - last_rise) != expD || rises > NPIX) strobe_err++;
      if (int'(pixel_index) != rises - 1) pix_err++;
    end
    if (frame_done) begin
      fd_cnt++;
      if (rises != NPIX + 1 || !(sensor_clk && !prev_sclk)) fd_bad++;
    end
    prev_sclk = sensor_clk;
    prev_si = sensor_si;
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int exp_half(input int h);
    return (h < MINH) ? MINH : h;
  endfunction
  function automatic int exp_settle(input int s, input int n);
    if (s == 0) return 1;
    if (s > 2 * n - 1) return 2 * n - 1;
    return s;
  endfunction

  task automatic clear_mon();
    tot_rises = 0; rises = 0; between = 0; setup = 0; strobes = 0;
    si_rises = 0; fd_cnt = 0; spacing_err = 0; strobe_err = 0;
    pix_err = 0; si_bad = 0; fd_bad = 0;
  endtask

  task automatic set_cfg(input int h, input int s, input int x);
    half_div = 8'(h); settle_dly = 8'(s); idle_clks = 8'(x);
    expN = exp_half(h); expD = exp_settle(s, expN);
    expP = NPIX + 1 + ((x == 0) ? 1 : x);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic check_run(input int nfr, input string tag);
    int snap;
    repeat (4 * expN + 4) @(posedge clk);
    #1 snap = tot_rises;
    chk("R4", tot_rises, expP * nfr, {tag, " rises per run"});
    chk("R2", spacing_err, 0, {tag, " clock phase errors"});
    chk("R3", setup, expN, {tag, " start-to-first-rise cycles"});
    chk("R3", si_bad, 0, {tag, " start pulse edge errors"});
    chk("R5", strobes, NPIX * nfr, {tag, " strobe count"});
    chk("R5", strobe_err, 0, {tag, " strobe delay errors"});
    chk("R6", pix_err, 0, {tag, " pixel index errors"});
    chk("R7", fd_cnt, nfr, {tag, " frame_done count"});
    chk("R7", fd_bad, 0, {tag, " frame_done placement errors"});
    chk("R9", si_rises, nfr, {tag, " start pulses"});
    repeat (4 * expN) @(posedge clk);
    #1;
    chk("R4", tot_rises - snap, 0, {tag, " rises while idle"});
    chk("R2", int'(sensor_clk), 0, {tag, " idle clock level"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(sensor_clk), 0, "sensor_clk after reset");
    chk("R1", int'(sensor_si), 0, "sensor_si after reset");
    chk("R1", int'(adc_sample), 0, "adc_sample after reset");
    chk("R1", int'(frame_done), 0, "frame_done after reset");
    chk("R1", int'(pixel_index), 0, "pixel_index after reset");

    // R2 R3 R4 R5 R6 R7 sweep over divider, settle and idle settings
    for (int h = 1; h <= 3; h++) begin
      for (int si = 0; si < 4; si++) begin
        int n = exp_half(h);
        int s = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 2 * n - 1 : 200;
        int x = (h + si) % 3 * 2;
        @(posedge clk); #1 clear_mon(); set_cfg(h, s, x);
        pulse_start();
        repeat (2 * expN * expP + 4) @(posedge clk);
        check_run(1, $sformatf("sweep h%0d s%0d x%0d", h, s, x));
      end
    end

    // R9 mid-frame setting changes and a start request during the frame
    @(posedge clk); #1 clear_mon(); set_cfg(3, 4, 7);
    pulse_start();
    repeat (30) @(posedge clk);
    #1 half_div = 8'd5; settle_dly = 8'd9; idle_clks = 8'd40;
    pulse_start();
    repeat (2 * expN * expP + 4) @(posedge clk);
    check_run(1, "r9_midframe");

    // R8 continuous: two frames back to back, then stop
    @(posedge clk); #1 clear_mon(); set_cfg(2, 3, 3);
    continuous = 1'b1;
    pulse_start();
    while (fd_cnt < 2) @(posedge clk);
    #1 continuous = 1'b0;
    repeat (2 * expN * expP + 4) @(posedge clk);
    chk("R8", between, expP, "rises between chained start pulses");
    check_run(2, "r8_chain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule